// File: doc/BRIEF.md
# Switch-Request Gating and Handshake Monitor

This block sits on the secondary side of an isolated converter. It decides when a cycle request may go to the primary switch, and it watches whether the primary still obeys those requests. The regulation loop raises `want_req` whenever it needs more energy. The block holds that wish as pending until every timing window has closed, and then emits one `req_out` pulse. A separate detector delivers `fwd_edge`, a one-cycle pulse that marks the end of primary conduction.

Several inhibits apply at the same time: a minimum spacing between requests, a minimum off-time after each conduction, a block while the primary conducts (with a timeout if the end of conduction is never seen), and, when `noise_en` is set, a skip window after each conduction that keeps the switching rate out of the audible band. Two counters track unanswered requests and primary cycles that nobody asked for. When either reaches its limit, the block fires a one-cycle `rehs_out` strobe so that the controller starts a new handshake. All limits are parameters counted in clock ticks. There are no data streams, so every pin is a plain control or status signal and no back-pressure applies.

Top module: `sreq_gate`

## Requirements
- R1: After reset, `req_out`, `rehs_out`, `on_inhibit` and `pending` are low, and a first request is not held back by any spacing, off-time or skip window.
- R2: When `want_req` (or a pending request) meets a cycle with no inhibit active, `req_out` is high for exactly one cycle in the following cycle.
- R3: Two `req_out` pulses are at least `MIN_PERIOD` cycles apart.
- R4: No request is issued in a cycle where `fwd_edge` is high, nor in the `MIN_OFF - 1` cycles after it. Issuing becomes possible `MIN_OFF` cycles after the edge cycle.
- R5: `on_inhibit` rises together with `req_out` and stays high until the cycle after a `fwd_edge`. No request is issued while it is high.
- R6: If no `fwd_edge` arrives, `on_inhibit` falls `TIMEOUT` cycles after it rose.
- R7: With `noise_en` high, no request is issued while the cycle count since the last `fwd_edge` cycle lies in [`SKIP_LO`, `SKIP_HI`).
- R8: With `noise_en` low, the skip window has no effect on when requests are issued.
- R9: A request that is held back sets `pending`. It stays pending and is issued in the first cycle in which all inhibits are clear, and `pending` then drops in the same cycle that `req_out` rises.
- R10: `MISS_LIMIT` (default 8) consecutive requests that end in a timeout fire `rehs_out`. Any `fwd_edge` resets this count.
- R11: `FREE_LIMIT` (default 4) consecutive `fwd_edge` pulses that arrive while `on_inhibit` is low fire `rehs_out`. Any issued request resets this count.
- R12: `rehs_out` is a single-cycle pulse, and both counts restart from zero when it fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| noise_en | input | 1 | Enables the audible-band skip window |
| want_req | input | 1 | Request wish from the regulation loop |
| fwd_edge | input | 1 | One-cycle pulse marking the end of primary conduction |
| req_out | output | 1 | Gated cycle request pulse |
| rehs_out | output | 1 | One-cycle strobe that asks for a new handshake |
| on_inhibit | output | 1 | High while primary conduction is assumed |
| pending | output | 1 | A request is waiting for its inhibits to clear |

## Verification
The gate is driven with single wishes whose edges return promptly, with a wish held high against periodic edges so that the spacing and off-time limits take turns being the binding constraint, and with wishes placed just after an edge. These patterns tell the off-time, the spacing and the on-time inhibit apart. The same edge-then-wish timing is run with the skip window enabled and disabled, which separates a skip-window suppression from an ordinary off-time delay. Requests that are never answered and edges that nobody requested exercise the two handshake counters separately, and an edge or a request inserted partway through shows that each counter is reset by the right event.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sreq_since.sv
// Saturating counter of cycles since the last restart pulse.
module sreq_since #(
  parameter int unsigned LIMIT = 16,
  parameter int unsigned W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 value <= W'(LIMIT);
    else if (restart)           value <= W'(1);
    else if (value < W'(LIMIT)) value <= value + W'(1);
  end
endmodule

// File: rtl/sreq_on_guard.sv
// On-time inhibit: set by an issued request, cleared by an edge or timeout.
module sreq_on_guard #(
  parameter int unsigned TIMEOUT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic edge_in,
  output logic on,
  output logic tmo
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] cnt;

  assign tmo = on & ~edge_in & (cnt == CW'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on  <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      on  <= 1'b1;
      cnt <= '0;
    end else if (on) begin
      if (edge_in || tmo) on <= 1'b0;
      else                cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sreq_cycle_mon.sv
// Counts unanswered requests and unrequested primary cycles.
module sreq_cycle_mon #(
  parameter int unsigned MISS_LIMIT = 8,
  parameter int unsigned FREE_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_in,
  input  logic on,
  input  logic issued,
  input  logic tmo,
  output logic rehs
);
  localparam int unsigned MW = $clog2(MISS_LIMIT + 1);
  localparam int unsigned FW = $clog2(FREE_LIMIT + 1);
  logic [MW-1:0] miss_q, miss_d;
  logic [FW-1:0] free_q, free_d;
  logic          fire;

  always_comb begin
    miss_d = miss_q;
    if (edge_in)  miss_d = '0;
    else if (tmo) miss_d = miss_q + MW'(1);
    free_d = free_q;
    if (issued)             free_d = '0;
    else if (edge_in && !on) free_d = free_q + FW'(1);
    fire = (miss_d == MW'(MISS_LIMIT)) || (free_d == FW'(FREE_LIMIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
      free_q <= '0;
      rehs   <= 1'b0;
    end else begin
      rehs   <= fire;
      miss_q <= fire ? '0 : miss_d;
      free_q <= fire ? '0 : free_d;
    end
  end
endmodule

// File: rtl/sreq_gate.sv
module sreq_gate #(
  parameter int unsigned MIN_PERIOD = 10,
  parameter int unsigned MIN_OFF    = 4,
  parameter int unsigned TIMEOUT    = 40,
  parameter int unsigned SKIP_LO    = 12,
  parameter int unsigned SKIP_HI    = 20,
  parameter int unsigned MISS_LIMIT = 8,
  parameter int unsigned FREE_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic noise_en,
  input  logic want_req,
  input  logic fwd_edge,
  output logic req_out,
  output logic rehs_out,
  output logic on_inhibit,
  output logic pending
);
  import sreq_pkg::*;

  localparam int unsigned CMAX = umax(MIN_OFF, SKIP_HI);
  localparam int unsigned RW   = $clog2(MIN_PERIOD + 1);
  localparam int unsigned CW   = $clog2(CMAX + 1);

  logic [RW-1:0] since_req;
  logic [CW-1:0] since_cond;
  logic          tmo, issue, in_skip, wish;

  sreq_since #(.LIMIT(MIN_PERIOD), .W(RW)) u_req_age (
    .clk(clk), .rst_n(rst_n), .restart(issue), .value(since_req)
  );

  sreq_since #(.LIMIT(CMAX), .W(CW)) u_cond_age (
    .clk(clk), .rst_n(rst_n), .restart(fwd_edge), .value(since_cond)
  );

  sreq_on_guard #(.TIMEOUT(TIMEOUT)) u_guard (
    .clk(clk), .rst_n(rst_n), .start(issue), .edge_in(fwd_edge),
    .on(on_inhibit), .tmo(tmo)
  );

  sreq_cycle_mon #(.MISS_LIMIT(MISS_LIMIT), .FREE_LIMIT(FREE_LIMIT)) u_mon (
    .clk(clk), .rst_n(rst_n), .edge_in(fwd_edge), .on(on_inhibit),
    .issued(issue), .tmo(tmo), .rehs(rehs_out)
  );

  always_comb begin
    wish    = pending | want_req;
    in_skip = noise_en && (since_cond >= CW'(SKIP_LO)) && (since_cond < CW'(SKIP_HI));
    issue   = wish && !fwd_edge && !on_inhibit && !in_skip
              && (since_req >= RW'(MIN_PERIOD))
              && (since_cond >= CW'(MIN_OFF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_out <= 1'b0;
      pending <= 1'b0;
    end else begin
      req_out <= issue;
      pending <= wish & ~issue;
    end
  end
endmodule

// File: rtl/sreq_gate_chk.sv
module sreq_gate_chk #(
  parameter int unsigned MIN_PERIOD = 10
) (
  input logic clk,
  input logic rst_n,
  input logic fwd_edge,
  input logic req_out,
  input logic rehs_out,
  input logic on_inhibit,
  input logic pending
);
  localparam int unsigned GW = $clog2(MIN_PERIOD + 1);
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap <= GW'(MIN_PERIOD);
    else if (req_out)              gap <= GW'(1);
    else if (gap < GW'(MIN_PERIOD)) gap <= gap + GW'(1);
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |=> !req_out); // R2
  AST_REQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> (gap >= GW'(MIN_PERIOD))); // R3
  AST_NO_REQ_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> !$past(fwd_edge)); // R4
  AST_NO_REQ_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> !$past(on_inhibit)); // R5
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> !pending); // R9
  AST_REHS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rehs_out |=> !rehs_out); // R12
endmodule

bind sreq_gate sreq_gate_chk #(.MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .fwd_edge(fwd_edge), .req_out(req_out),
  .rehs_out(rehs_out), .on_inhibit(on_inhibit), .pending(pending)
);

// File: tb/sim_sreq_gate.sv
`timescale 1ns/1ps
module sim_sreq_gate;
  localparam int MIN_PERIOD = 10, MIN_OFF = 4, TIMEOUT = 40;
  localparam int SKIP_LO = 12, SKIP_HI = 20, MISS_LIMIT = 8, FREE_LIMIT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic noise_en = 1'b0, want_req = 1'b0, fwd_edge = 1'b0;
  logic req_out, rehs_out, on_inhibit, pending;

  sreq_gate #(.MIN_PERIOD(MIN_PERIOD), .MIN_OFF(MIN_OFF), .TIMEOUT(TIMEOUT),
    .SKIP_LO(SKIP_LO), .SKIP_HI(SKIP_HI), .MISS_LIMIT(MISS_LIMIT),
    .FREE_LIMIT(FREE_LIMIT)) u0 (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference, timestamp based
  int n, last_iss, last_edge, on_start, miss, free;
  bit m_pend, m_on, m_req, m_rehs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n = 0; last_iss = -1000; last_edge = -1000; on_start = 0;
      miss = 0; free = 0; m_pend = 0; m_on = 0; m_req = 0; m_rehs = 0;
    end else begin
      int d;
      bit iss, tmo, unreq;
      d     = n - last_edge;
      iss   = (m_pend || want_req) && (n - last_iss >= MIN_PERIOD) && !m_on &&
              (d >= MIN_OFF) && !(noise_en && d >= SKIP_LO && d < SKIP_HI) && !fwd_edge;
      tmo   = m_on && !fwd_edge && (n - on_start == TIMEOUT);
      unreq = fwd_edge && !m_on;
      if (fwd_edge) miss = 0; else if (tmo) miss++;
      if (iss) free = 0; else if (unreq) free++;
      m_rehs = (miss == MISS_LIMIT) || (free == FREE_LIMIT);
      if (m_rehs) begin miss = 0; free = 0; end
      if (m_on && (fwd_edge || tmo)) m_on = 0;
      if (iss) begin m_on = 1; on_start = n; last_iss = n; end
      if (fwd_edge) last_edge = n;
      m_pend = (m_pend || want_req) && !iss;
      m_req  = iss;
      n++;
    end
  end

  task automatic cmp(input string what, input logic act, input bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %b expected %b at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cmp("req_out", req_out, m_req);
    cmp("rehs_out", rehs_out, m_rehs);
    cmp("on_inhibit", on_inhibit, m_on);
    cmp("pending", pending, m_pend);
  end

  task automatic tick(input bit w, input bit e);
    @(negedge clk); want_req = w; fwd_edge = e;
  endtask
  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick(0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog expired in %s", tag);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values checked directly
    vectors += 4;
    if (req_out !== 0 || rehs_out !== 0 || on_inhibit !== 0 || pending !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b%b%b%b expected 0000",
               req_out, rehs_out, on_inhibit, pending);
    end
    rst_n = 1'b1;
    tag = "R1"; tick(1, 0); idle(3); tick(0, 1); idle(15);

    tag = "R2";
    for (int r = 0; r < 3; r++) begin tick(1, 0); idle(3); tick(0, 1); idle(15); end

    tag = "R3";
    for (int k = 0; k < 60; k++) tick(1, (k % 6) == 3);
    idle(20);

    tag = "R4";
    tick(0, 1); tick(1, 0); idle(3); tick(0, 1); idle(20);
    tick(0, 1); idle(2); tick(1, 0); idle(20);

    tag = "R7"; noise_en = 1;
    idle(25); tick(0, 1); idle(12); tick(1, 0); idle(12); tick(0, 1); idle(25);
    tick(0, 1); idle(5); tick(1, 0); idle(4); tick(0, 1); idle(25);

    tag = "R8"; noise_en = 0;
    idle(25); tick(0, 1); idle(12); tick(1, 0); idle(4); tick(0, 1); idle(25);

    tag = "R9";
    tick(1, 0); idle(2); tick(1, 0); idle(6); tick(0, 1); idle(25);

    tag = "R6";
    tick(1, 0); idle(TIMEOUT + 5);
    tag = "R10";
    for (int r = 0; r < 4; r++) begin tick(1, 0); idle(TIMEOUT + 5); end
    tick(0, 1); idle(10);
    for (int r = 0; r < MISS_LIMIT + 1; r++) begin tick(1, 0); idle(TIMEOUT + 5); end

    tag = "R11";
    for (int r = 0; r < 3; r++) begin tick(0, 1); idle(6); end
    tick(1, 0); idle(3); tick(0, 1); idle(15);
    for (int r = 0; r < FREE_LIMIT + 1; r++) begin tick(0, 1); idle(6); end

    tag = "R12";
    for (int r = 0; r < 2 * FREE_LIMIT; r++) begin tick(0, 1); idle(3); end
    idle(10);
    finish_run();
  end
endmodule